// File: doc/BRIEF.md
# Supply and Battery Monitor Sequencer

This block sits between the analog supervision of a battery-backed memory with a real-time clock and the rest of that device. It watches three comparator flags: supply in tolerance, supply below the battery, and battery below its low threshold. From these it decides when the memory may be selected. It gates chip select off as soon as the supply leaves tolerance or falls below the battery. It holds the gate closed for a recovery time after the supply comes back, and it issues a one-cycle clear for the clock's halt-for-read and halt-for-set control bits.

The battery check needs the supply to be nominal. The block enables the battery comparator once after each recovery and again every `CHECK_SEC` ticks of a 1 Hz timebase (one day by default). It stores the result in a sticky battery-low flag, and only a later check that completes can change that flag. The comparator inputs pass through two-flop synchronizers. The tick input is a single-cycle pulse in the clock domain.

Top module: `supply_sequencer`

## Requirements
- R1: During and right after reset, `cs_gate`, `cmp_en`, `ctl_clr` and `bat_flag` are all 0.
- R2: If `vcc_ok_in` is 0 or `below_bat_in` is 1 at three clock edges in a row, `cs_gate` is 0 after the third edge and stays 0 until a new power-up sequence completes.
- R3: A new power-up sequence starts when the supply becomes good, meaning `vcc_ok_in`=1 and `below_bat_in`=0. `cs_gate` stays 0 for 2 synchronizer cycles + 1 + `RECOVER_CYC` + `SETTLE_CYC` clock cycles after the supply becomes good.
- R4: `ctl_clr` is a single-cycle pulse in the last recovery cycle, while `cs_gate` is still 0.
- R5: Right after recovery, `cmp_en` is 1 for exactly `SETTLE_CYC` cycles with `cs_gate` at 0. `cs_gate` rises in the cycle after `cmp_en` falls.
- R6: At the end of each completed check, `bat_flag` takes the synchronized value of `bat_low_in`, where 1 means the battery is low.
- R7: `bat_flag` changes only at the end of a completed check. A change on `bat_low_in` at any other time has no effect on it.
- R8: While in service, the `CHECK_SEC`-th `tick_1hz` pulse after the last check starts a periodic check. `cmp_en` is 1 in the cycle after that tick, and `cs_gate` stays 1 throughout the check.
- R9: Ticks that arrive while the supply is off or recovering are ignored, and the interval restarts at every power-up.
- R10: Loss of supply during a check aborts it and leaves `bat_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok_in | input | 1 | Comparator: supply within tolerance |
| below_bat_in | input | 1 | Comparator: supply below battery voltage |
| bat_low_in | input | 1 | Comparator: battery below low threshold (valid while `cmp_en`) |
| tick_1hz | input | 1 | One-cycle pulse per second |
| cs_gate | output | 1 | 1 = memory may be selected |
| ctl_clr | output | 1 | One-cycle clear for clock read/write halt bits |
| bat_flag | output | 1 | Sticky battery-low flag bit |
| cmp_en | output | 1 | Enables the battery comparator |

## Verification
Two things can land in the same cycle: a battery check completing, and the supply being lost. The bench provokes this by dropping `vcc_ok_in` in the cycle right after a periodic check has started, with `bat_low_in` set opposite to the stored flag. The gate must close three edges later, and the flag must keep its old value after the next power-up test is skipped. A second overlap is a scheduled tick arriving while the supply is away. The bench judges it by requiring the next periodic check to land exactly `CHECK_SEC` ticks after the power-up test.

// File: rtl/supply_sequencer.sv
module supply_sequencer #(
  parameter int RECOVER_CYC = 100000,
  parameter int SETTLE_CYC  = 16,
  parameter int CHECK_SEC   = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok_in,
  input  logic below_bat_in,
  input  logic bat_low_in,
  input  logic tick_1hz,
  output logic cs_gate,
  output logic ctl_clr,
  output logic bat_flag,
  output logic cmp_en
);
  localparam int CMAX = (RECOVER_CYC > SETTLE_CYC) ? RECOVER_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int SW   = $clog2(CHECK_SEC + 1);

  typedef enum logic [2:0] {OFF, RECOVER, PU_TEST, SERVICE, PER_TEST} st_t;

  st_t           st;
  logic [2:0]    m1, m2;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sec;
  logic          good, rec_last, test_last;

  assign good      = m2[0] & ~m2[1];
  assign rec_last  = (cnt == CW'(RECOVER_CYC - 1));
  assign test_last = (cnt == CW'(SETTLE_CYC - 1));

  assign cs_gate = (st == SERVICE) || (st == PER_TEST);
  assign cmp_en  = (st == PU_TEST) || (st == PER_TEST);
  assign ctl_clr = (st == RECOVER) && good && rec_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 3'b010;
      m2 <= 3'b010;
    end else begin
      m1 <= {bat_low_in, below_bat_in, vcc_ok_in};
      m2 <= m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= OFF;
      cnt      <= '0;
      sec      <= '0;
      bat_flag <= 1'b0;
    end else if (!good) begin
      st  <= OFF;
      cnt <= '0;
      sec <= '0;
    end else begin
      unique case (st)
        OFF: begin
          st  <= RECOVER;
          cnt <= '0;
        end
        RECOVER: begin
          if (rec_last) begin
            st  <= PU_TEST;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PU_TEST, PER_TEST: begin
          if (test_last) begin
            bat_flag <= m2[2];
            st       <= SERVICE;
            cnt      <= '0;
            sec      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SERVICE: begin
          if (tick_1hz) begin
            if (sec == SW'(CHECK_SEC - 1)) begin
              sec <= '0;
              cnt <= '0;
              st  <= PER_TEST;
            end else begin
              sec <= sec + 1'b1;
            end
          end
        end
        default: st <= OFF;
      endcase
    end
  end
endmodule

// File: rtl/supply_sequencer_props.sv
module supply_sequencer_props (
  input logic clk,
  input logic rst_n,
  input logic vcc_ok_in,
  input logic below_bat_in,
  input logic cs_gate,
  input logic ctl_clr,
  input logic bat_flag,
  input logic cmp_en
);
  p_gate_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_ok_in && $past(!vcc_ok_in) && $past(!vcc_ok_in, 2)) |=> !cs_gate);

  p_gate_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (below_bat_in && $past(below_bat_in) && $past(below_bat_in, 2)) |=> !cs_gate);

  p_no_test_on_batt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_ok_in && $past(!vcc_ok_in) && $past(!vcc_ok_in, 2)) |=> !cmp_en);

  p_clr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |=> !ctl_clr);

  p_clr_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |-> !cs_gate && !cmp_en);

  p_test_after_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |=> cmp_en || !vcc_ok_in || below_bat_in || !$past(vcc_ok_in) || $past(below_bat_in) || !cs_gate);

  p_gate_after_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_gate) |-> $past(cmp_en));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmp_en) |-> $stable(bat_flag));
endmodule

bind supply_sequencer supply_sequencer_props u_props (
  .clk(clk), .rst_n(rst_n), .vcc_ok_in(vcc_ok_in), .below_bat_in(below_bat_in),
  .cs_gate(cs_gate), .ctl_clr(ctl_clr), .bat_flag(bat_flag), .cmp_en(cmp_en)
);

// File: tb/supply_sequencer_test.sv
module supply_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int REC = 20;
  localparam int SET = 6;
  localparam int SEC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok_in = 1'b0;
  logic below_bat_in = 1'b0;
  logic bat_low_in = 1'b0;
  logic tick_1hz = 1'b0;
  logic cs_gate, ctl_clr, bat_flag, cmp_en;

  int checks = 0;
  int errors = 0;
  bit exp_flag = 1'b0;

  supply_sequencer #(.RECOVER_CYC(REC), .SETTLE_CYC(SET), .CHECK_SEC(SEC)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_ok_in(vcc_ok_in), .below_bat_in(below_bat_in),
    .bat_low_in(bat_low_in), .tick_1hz(tick_1hz), .cs_gate(cs_gate),
    .ctl_clr(ctl_clr), .bat_flag(bat_flag), .cmp_en(cmp_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int latency_open();
    return 3 + REC + SET;
  endfunction

  task automatic power_up(input bit via_below, input bit bl);
    bat_low_in = bl;
    if (via_below) below_bat_in = 1'b0; else vcc_ok_in = 1'b1;
    for (int i = 1; i <= latency_open(); i++) begin
      step();
      if (i == REC + 1) chk(ctl_clr == 1'b0, "R4 clr early", ctl_clr, 0);
      if (i == REC + 2) begin
        chk(ctl_clr == 1'b1, "R4 clr pulse", ctl_clr, 1);
        chk(cs_gate == 1'b0, "R3 gate in recovery", cs_gate, 0);
        chk(cmp_en == 1'b0, "R5 no strobe in recovery", cmp_en, 0);
      end
      if (i == REC + 3) begin
        chk(ctl_clr == 1'b0, "R4 clr single", ctl_clr, 0);
        chk(cmp_en == 1'b1, "R5 strobe start", cmp_en, 1);
      end
      if (i == latency_open() - 1) begin
        chk(cs_gate == 1'b0, "R3 gate before open", cs_gate, 0);
        chk(cmp_en == 1'b1, "R5 strobe end", cmp_en, 1);
      end
    end
    exp_flag = bl;
    chk(cs_gate == 1'b1, "R5 gate open", cs_gate, 1);
    chk(cmp_en == 1'b0, "R5 strobe off", cmp_en, 0);
    chk(bat_flag == exp_flag, "R6 powerup result", bat_flag, exp_flag);
  endtask

  task automatic power_down(input bit via_below);
    if (via_below) below_bat_in = 1'b1; else vcc_ok_in = 1'b0;
    step(); step();
    chk(cs_gate == 1'b1, "R2 gate sync delay", cs_gate, 1);
    step();
    chk(cs_gate == 1'b0, "R2 gate closed", cs_gate, 0);
    repeat (4) step();
    chk(cs_gate == 1'b0 && cmp_en == 1'b0, "R2 stays closed", cs_gate, 0);
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    step();
    tick_1hz = 1'b0;
  endtask

  task automatic periodic(input bit bl);
    bat_low_in = bl;
    repeat (3) step();
    for (int t = 1; t <= SEC; t++) begin
      repeat ($urandom_range(0, 3)) step();
      tick();
      if (t < SEC) chk(cmp_en == 1'b0, "R8 no early check", cmp_en, 0);
    end
    chk(cmp_en == 1'b1, "R8 check starts", cmp_en, 1);
    for (int i = 1; i <= SET; i++) begin
      step();
      chk(cs_gate == 1'b1, "R8 gate open in check", cs_gate, 1);
    end
    exp_flag = bl;
    chk(cmp_en == 1'b0, "R8 check ends", cmp_en, 0);
    chk(bat_flag == exp_flag, "R6 periodic result", bat_flag, exp_flag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) step();
    chk(cs_gate == 0 && cmp_en == 0 && ctl_clr == 0 && bat_flag == 0, "R1 reset", cs_gate, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk(cs_gate == 0 && cmp_en == 0 && ctl_clr == 0 && bat_flag == 0, "R1 after reset", bat_flag, 0);

    power_up(1'b0, 1'b1);
    periodic(1'b0);

    bat_low_in = 1'b1;
    repeat (10) step();
    chk(bat_flag == exp_flag, "R7 input ignored outside check", bat_flag, exp_flag);
    bat_low_in = 1'b0;

    power_down(1'b1);
    power_up(1'b1, 1'b0);

    // R10: supply lost right after a periodic check starts
    bat_low_in = ~exp_flag;
    repeat (3) step();
    for (int t = 1; t <= SEC; t++) tick();
    chk(cmp_en == 1'b1, "R10 check entered", cmp_en, 1);
    power_down(1'b0);
    repeat (SET + 2) step();
    chk(bat_flag == exp_flag, "R10 aborted check keeps flag", bat_flag, exp_flag);

    // R9: ticks while off are ignored; interval restarts
    for (int t = 0; t < 7; t++) tick();
    chk(cmp_en == 1'b0, "R9 no check while off", cmp_en, 0);
    power_up(1'b0, 1'b1);
    periodic(1'b0);

    for (int k = 0; k < 6; k++) begin
      bit vb = $urandom_range(0, 1);
      power_down(vb);
      power_up(vb, 1'($urandom_range(0, 1)));
      periodic(1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule